// File: doc/BRIEF.md
# Divider-Based Bit Clock Recovery

This block recovers a line-rate bit clock and retimed data from the sliced bipolar pulses of a T1 or E1 primary-rate line. It runs from a reference clock at twelve times the nominal line rate. A bit-window counter counts reference cycles, and each window is cut to 11, 12 or 13 cycles depending on where the first mark edge of that window lands. This pulls the window start toward the phase of the incoming pulses.

Each window produces a one-cycle enable at its start and a toggling clock that is high for the first half of the window. The positive and negative rails are sampled in mid-window and presented one window later on the retimed outputs. A lock flag rises once a run of well-centred mark edges has been seen. It falls at once when the carrier-loss input is asserted or when the rate select changes. In T1 mode the reference is 18.528 MHz and in E1 mode it is 24.576 MHz, so the divider behaves the same in both modes.

Top module: `bitclk_recover`

## Requirements
- R1: Every recovered bit window lasts 11, 12 or 13 reference cycles. `rclk_en` is high for exactly the first cycle of each window.
- R2: `rclk` is high for the first 6 reference cycles of each window and low for the remaining cycles.
- R3: Window counts run from 0 at `rclk_en`. The line inputs pass one register stage, and the edge position is the count at which the registered OR of both rails first rises within a window. If that position is below 3, the window is 11 cycles. If it is above 3, the window is 13 cycles. If it is exactly 3, the window is 12 cycles. As a result, a steady source at 11 or 13 cycles per bit is tracked with no window slip.
- R4: A window that contains no mark edge lasts 12 cycles.
- R5: Each rail is sampled at window count 6. The sample appears on `rpos`/`rneg` (a positive mark is 10 and a negative mark is 01) from the start of the following window. The outputs change only in a cycle where `rclk_en` is high.
- R6: `locked` rises after LOCK_BITS (default 32) consecutive edged windows whose edge position lies within 2..4. A window before lock whose edge lies outside 2..4 restarts the count. Windows without an edge leave the count and the lock unchanged, so `locked` can never rise sooner than LOCK_BITS windows after it was last cleared.
- R7: While `carrier_loss` is high, `locked` is low from the next reference edge and the run count is cleared.
- R8: Any change of `rate_e1` drops `locked` on the next reference edge and restarts acquisition. The window ratios are the same in both rate modes.
- R9: While in reset, and in the first cycle after reset, the window count is 0 (`rclk_en` and `rclk` high), `locked` is low and `rpos`/`rneg` are 0. Reset is asynchronous and its release is synchronised over two reference edges.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_ref | input | 1 | Reference clock, 12x nominal line rate |
| rst_n | input | 1 | Asynchronous active-low reset |
| line_pos | input | 1 | Sliced positive-rail pulse |
| line_neg | input | 1 | Sliced negative-rail pulse |
| rate_e1 | input | 1 | Rate select: 0 for T1, 1 for E1 |
| carrier_loss | input | 1 | Carrier loss flag from the line monitor |
| rclk_en | output | 1 | One-cycle enable at each recovered bit start |
| rclk | output | 1 | Recovered bit clock, high for the first half of the window |
| rpos | output | 1 | Retimed positive-rail data |
| rneg | output | 1 | Retimed negative-rail data |
| locked | output | 1 | Tracking established; data valid while high |

## Verification
The embedded assertions check the following on every cycle:
- the window counter advances by one and stays within the 13-cycle bound;
- an 11-cycle window only ends where an edge was seen;
- the retimed data holds between window starts;
- lock drops one edge after carrier loss or a rate change;
- lock only rises at the close of a well-centred window.

Only the bench scenarios can show the properties that need many windows:
- that a free-running source at an arbitrary phase is pulled in to the centre;
- that 11- and 13-cycle sources are tracked without slipping a bit;
- that the recovered data stream matches the transmitted one;
- that lock takes at least LOCK_BITS windows and never comes while edges are periodically displaced.

// File: rtl/bcr_pkg.sv
package bcr_pkg;
  typedef enum logic [1:0] {
    PH_NONE   = 2'd0,
    PH_EARLY  = 2'd1,
    PH_CENTRE = 2'd2,
    PH_LATE   = 2'd3
  } phase_e;
endpackage

// File: rtl/bcr_edge_in.sv
module bcr_edge_in (
  input  logic clk,
  input  logic rst_ni,
  input  logic pos_i,
  input  logic neg_i,
  output logic pos_o,
  output logic neg_o,
  output logic edge_o
);
  logic pos_q, neg_q, lvl_qq;
  logic pos_d, neg_d, lvl_d;

  always_comb begin
    pos_d = pos_i;
    neg_d = neg_i;
    lvl_d = pos_q | neg_q;
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      pos_q  <= 1'b0;
      neg_q  <= 1'b0;
      lvl_qq <= 1'b0;
    end else begin
      pos_q  <= pos_d;
      neg_q  <= neg_d;
      lvl_qq <= lvl_d;
    end
  end

  assign pos_o  = pos_q;
  assign neg_o  = neg_q;
  assign edge_o = (pos_q | neg_q) & ~lvl_qq;

  // R3: a detected edge is a single-cycle event
  p_edge_single_r3: assert property (@(posedge clk) disable iff (!rst_ni)
    edge_o |=> !edge_o);
endmodule

// File: rtl/bcr_phase_div.sv
module bcr_phase_div
  import bcr_pkg::*;
#(
  parameter int NOM_DIV = 12,
  parameter int CENTRE  = 3,
  parameter int CW      = $clog2(NOM_DIV + 2)
) (
  input  logic          clk,
  input  logic          rst_ni,
  input  logic          edge_i,
  output logic [CW-1:0] cnt_o,
  output logic          win_last_o,
  output logic          win_edge_o,
  output logic          win_good_o
);
  localparam logic [CW-1:0] END_SHORT = CW'(NOM_DIV - 2);
  localparam logic [CW-1:0] END_NOM   = CW'(NOM_DIV - 1);
  localparam logic [CW-1:0] END_LONG  = CW'(NOM_DIV);
  localparam logic [CW-1:0] C_POS     = CW'(CENTRE);
  localparam logic [CW-1:0] C_LO      = CW'(CENTRE - 1);
  localparam logic [CW-1:0] C_HI      = CW'(CENTRE + 1);

  logic [CW-1:0] cnt_q, cnt_d;
  logic [CW-1:0] end_q, end_d;
  logic          seen_q, seen_d;
  logic          good_q, good_d;
  logic          first_edge, last;
  logic [CW-1:0] end_pick, end_now;
  logic          good_pick;
  phase_e        phase;

  always_comb begin
    first_edge = edge_i & ~seen_q;
    if (!first_edge)         phase = PH_NONE;
    else if (cnt_q < C_POS)  phase = PH_EARLY;
    else if (cnt_q > C_POS)  phase = PH_LATE;
    else                     phase = PH_CENTRE;

    unique case (phase)
      PH_EARLY: end_pick = END_SHORT;
      PH_LATE:  end_pick = END_LONG;
      default:  end_pick = END_NOM;
    endcase
    good_pick = first_edge && (cnt_q >= C_LO) && (cnt_q <= C_HI);

    end_now = seen_q ? end_q : end_pick;
    last    = (cnt_q == end_now);

    cnt_d  = last ? '0 : cnt_q + 1'b1;
    seen_d = last ? 1'b0 : (seen_q | edge_i);
    end_d  = first_edge ? end_pick : end_q;
    good_d = last ? 1'b0 : (seen_q ? good_q : good_pick);
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      end_q  <= END_NOM;
      seen_q <= 1'b0;
      good_q <= 1'b0;
    end else begin
      cnt_q  <= cnt_d;
      end_q  <= end_d;
      seen_q <= seen_d;
      good_q <= good_d;
    end
  end

  assign cnt_o      = cnt_q;
  assign win_last_o = last;
  assign win_edge_o = seen_q | edge_i;
  assign win_good_o = seen_q ? good_q : good_pick;

  // R1: the counter never passes the longest window
  p_cnt_range_r1: assert property (@(posedge clk) disable iff (!rst_ni)
    cnt_q <= END_LONG);
  // R1: inside a window the counter steps by one
  p_cnt_step_r1: assert property (@(posedge clk) disable iff (!rst_ni)
    (cnt_q != '0) |-> (cnt_q == $past(cnt_q) + 1'b1));
  // R3: a short window can only close after an edge
  p_short_needs_edge_r3: assert property (@(posedge clk) disable iff (!rst_ni)
    (last && cnt_q == END_SHORT) |-> win_edge_o);
endmodule

// File: rtl/bcr_data_retime.sv
module bcr_data_retime #(
  parameter int SAMPLE_AT = 6,
  parameter int CW        = 4
) (
  input  logic          clk,
  input  logic          rst_ni,
  input  logic [CW-1:0] cnt_i,
  input  logic          win_last_i,
  input  logic          pos_i,
  input  logic          neg_i,
  output logic          rpos_o,
  output logic          rneg_o
);
  localparam logic [CW-1:0] SAMP_CNT = CW'(SAMPLE_AT);

  logic [1:0] samp_q, samp_d;
  logic [1:0] out_q, out_d;
  logic       samp_en;

  always_comb begin
    samp_en = (cnt_i == SAMP_CNT);
    samp_d  = samp_en ? {pos_i, neg_i} : samp_q;
    out_d   = win_last_i ? samp_q : out_q;
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      samp_q <= 2'b00;
      out_q  <= 2'b00;
    end else begin
      samp_q <= samp_d;
      out_q  <= out_d;
    end
  end

  assign rpos_o = out_q[1];
  assign rneg_o = out_q[0];

  // R5: outputs only move at a window boundary
  p_hold_r5: assert property (@(posedge clk) disable iff (!rst_ni)
    !win_last_i |=> $stable(out_q));
endmodule

// File: rtl/bcr_lock_det.sv
module bcr_lock_det #(
  parameter int LOCK_BITS = 32,
  parameter int LW        = $clog2(LOCK_BITS + 1)
) (
  input  logic clk,
  input  logic rst_ni,
  input  logic rate_i,
  input  logic carrier_loss_i,
  input  logic win_last_i,
  input  logic win_edge_i,
  input  logic win_good_i,
  output logic locked_o
);
  localparam logic [LW-1:0] RUN_MAX = LW'(LOCK_BITS);

  logic [LW-1:0] run_q, run_d;
  logic          lock_q, lock_d;
  logic          rate_q;
  logic          clear, judge;

  always_comb begin
    clear  = carrier_loss_i | (rate_i != rate_q);
    judge  = win_last_i & win_edge_i & ~lock_q;
    run_d  = run_q;
    lock_d = lock_q;
    if (clear) begin
      run_d  = '0;
      lock_d = 1'b0;
    end else if (judge) begin
      if (win_good_i) begin
        run_d = run_q + 1'b1;
        if (run_q + 1'b1 == RUN_MAX) lock_d = 1'b1;
      end else begin
        run_d = '0;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      run_q  <= '0;
      lock_q <= 1'b0;
      rate_q <= 1'b0;
    end else begin
      run_q  <= run_d;
      lock_q <= lock_d;
      rate_q <= rate_i;
    end
  end

  assign locked_o = lock_q;

  // R7: carrier loss removes lock on the next edge
  p_loss_drops_r7: assert property (@(posedge clk) disable iff (!rst_ni)
    carrier_loss_i |=> !locked_o);
  // R8: a rate change removes lock on the next edge
  p_rate_drops_r8: assert property (@(posedge clk) disable iff (!rst_ni)
    (rate_i != rate_q) |=> !locked_o);
  // R6: lock only rises at the close of a centred window
  p_lock_rise_r6: assert property (@(posedge clk) disable iff (!rst_ni)
    $rose(locked_o) |-> $past(win_last_i && win_good_i && !carrier_loss_i));
endmodule

// File: rtl/bitclk_recover.sv
module bitclk_recover #(
  parameter int NOM_DIV   = 12,
  parameter int LOCK_BITS = 32
) (
  input  logic clk_ref,
  input  logic rst_n,
  input  logic line_pos,
  input  logic line_neg,
  input  logic rate_e1,
  input  logic carrier_loss,
  output logic rclk_en,
  output logic rclk,
  output logic rpos,
  output logic rneg,
  output logic locked
);
  localparam int CW        = $clog2(NOM_DIV + 2);
  localparam int HALF      = NOM_DIV / 2;
  localparam int CENTRE    = NOM_DIV / 4;
  localparam int SAMPLE_AT = NOM_DIV / 2;

  logic [1:0]    rst_sync_q;
  logic          rst_s_n;
  logic          pos_r, neg_r, edge_r;
  logic [CW-1:0] cnt;
  logic          win_last, win_edge, win_good;

  always_ff @(posedge clk_ref or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_s_n = rst_sync_q[1];

  bcr_edge_in u_edge (
    .clk    (clk_ref),
    .rst_ni (rst_s_n),
    .pos_i  (line_pos),
    .neg_i  (line_neg),
    .pos_o  (pos_r),
    .neg_o  (neg_r),
    .edge_o (edge_r)
  );

  bcr_phase_div #(.NOM_DIV(NOM_DIV), .CENTRE(CENTRE), .CW(CW)) u_div (
    .clk        (clk_ref),
    .rst_ni     (rst_s_n),
    .edge_i     (edge_r),
    .cnt_o      (cnt),
    .win_last_o (win_last),
    .win_edge_o (win_edge),
    .win_good_o (win_good)
  );

  bcr_data_retime #(.SAMPLE_AT(SAMPLE_AT), .CW(CW)) u_data (
    .clk        (clk_ref),
    .rst_ni     (rst_s_n),
    .cnt_i      (cnt),
    .win_last_i (win_last),
    .pos_i      (pos_r),
    .neg_i      (neg_r),
    .rpos_o     (rpos),
    .rneg_o     (rneg)
  );

  bcr_lock_det #(.LOCK_BITS(LOCK_BITS)) u_lock (
    .clk            (clk_ref),
    .rst_ni         (rst_s_n),
    .rate_i         (rate_e1),
    .carrier_loss_i (carrier_loss),
    .win_last_i     (win_last),
    .win_edge_i     (win_edge),
    .win_good_i     (win_good),
    .locked_o       (locked)
  );

  assign rclk_en = (cnt == '0);
  assign rclk    = (cnt < CW'(HALF));

  // R2: the clock is high at every window start
  p_clk_shape_r2: assert property (@(posedge clk_ref) disable iff (!rst_s_n)
    rclk_en |-> rclk);
  // R9: first cycle after reset release starts a window unlocked
  p_reset_state_r9: assert property (@(posedge clk_ref)
    !rst_s_n |=> (rclk_en && !locked && !rpos && !rneg));
endmodule

// File: tb/test_bitclk_recover.sv
module test_bitclk_recover;
  localparam int LOCK_BITS = 32;
  localparam int HALF      = 6;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic rst_n, line_pos, line_neg, rate_e1, carrier_loss;
  logic rclk_en, rclk, rpos, rneg, locked;

  bitclk_recover i_bitclk_recover (
    .clk_ref(clk), .rst_n(rst_n), .line_pos(line_pos), .line_neg(line_neg),
    .rate_e1(rate_e1), .carrier_loss(carrier_loss), .rclk_en(rclk_en),
    .rclk(rclk), .rpos(rpos), .rneg(rneg), .locked(locked)
  );

  int n_chk = 0, n_bad = 0;
  int pos_w = 0, win_cnt = 0, lock_win = 0, cyc = 0;
  int n11 = 0, n12 = 0, n13 = 0;
  bit have = 0, mon_on = 0, lock_seen = 0, rec_on = 0, done = 0;
  logic [1:0] prev_d = 2'b00;
  logic prev_lock = 1'b0;
  logic [1:0] rec_q[$];
  logic [1:0] sent[64];

  function automatic bit period_ok(int g);
    return (g >= 11) && (g <= 13);
  endfunction
  function automatic bit near(int a, int b, int tol);
    return (a >= b - tol) && (a <= b + tol);
  endfunction

  task automatic chk(bit ok, string req, int act, int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d t=%0t", req, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    cyc++;
    if (mon_on) begin
      if (rclk_en) begin
        if (have) begin
          chk(period_ok(pos_w + 1), "R1 window length", pos_w + 1, 12);
          if (pos_w + 1 == 11) n11++;
          else if (pos_w + 1 == 12) n12++;
          else n13++;
        end
        have = 1;
        pos_w = 0;
        win_cnt++;
        if (rec_on) rec_q.push_back({rpos, rneg});
      end else begin
        pos_w++;
        chk({rpos, rneg} == prev_d, "R5 data held inside window",
            {rpos, rneg}, prev_d);
      end
      if (have) chk(rclk == (pos_w < HALF), "R2 rclk shape", rclk, pos_w < HALF);
      if (locked && !prev_lock) begin
        lock_seen = 1;
        lock_win  = win_cnt;
      end
    end
    prev_d    = {rpos, rneg};
    prev_lock = locked;
  end

  task automatic send_bit(bit p, bit n, int per, int dly);
    for (int i = 0; i < per; i++) begin
      @(negedge clk);
      line_pos = p && (i >= dly) && (i < dly + per / 2);
      line_neg = n && (i >= dly) && (i < dly + per / 2);
    end
  endtask

  task automatic clr_stats();
    n11 = 0; n12 = 0; n13 = 0;
  endtask

  task automatic expect_lock(string req);
    int base;
    base = win_cnt;
    lock_seen = 0;
    for (int b = 0; b < 70 && !lock_seen; b++) send_bit(1, 0, 12, 0);
    chk(lock_seen, req, lock_seen, 1);
    chk(lock_win - base >= LOCK_BITS && lock_win - base <= LOCK_BITS + 14,
        {req, " lock delay"}, lock_win - base, LOCK_BITS);
  endtask

  initial begin
    int seed, base, k, r;
    seed = $urandom(32'd52191);
    rst_n = 0; line_pos = 0; line_neg = 0; rate_e1 = 0; carrier_loss = 0;
    repeat (5) @(negedge clk);
    // R9 reset state
    chk(rclk_en == 1 && rclk == 1, "R9 counter at zero", {rclk_en, rclk}, 3);
    chk(locked == 0, "R9 unlocked", locked, 0);
    chk({rpos, rneg} == 2'b00, "R9 data clear", {rpos, rneg}, 0);
    rst_n = 1;
    @(negedge clk); @(negedge clk);
    chk(rclk_en == 1 && locked == 0, "R9 first cycle", {rclk_en, locked}, 2);
    mon_on = 1;
    send_bit(0, 0, 5, 0);           // arbitrary starting phase

    // R3/R6: pull-in from arbitrary phase and lock timing
    expect_lock("R6 acquisition");
    clr_stats();
    repeat (20) send_bit(1, 0, 12, 0);
    chk(n11 == 0 && n13 == 0, "R3 centred edges keep 12", n11 + n13, 0);

    // R5: data path with marker and random marks
    for (int i = 0; i < 64; i++) begin
      r = $urandom % 4;
      sent[i] = (r == 2) ? 2'b01 : ((r == 0) ? 2'b00 : 2'b10);
    end
    rec_q.delete();
    rec_on = 1;
    send_bit(0, 1, 12, 0);
    for (int i = 0; i < 64; i++) send_bit(sent[i][1], sent[i][0], 12, 0);
    repeat (3) send_bit(0, 0, 12, 0);
    rec_on = 0;
    k = -1;
    for (int i = 0; i < rec_q.size() && k < 0; i++) if (rec_q[i] == 2'b01) k = i;
    chk(k >= 0, "R5 marker found", k, 0);
    if (k >= 0)
      for (int i = 0; i < 64; i++) begin
        if (k + 1 + i < rec_q.size())
          chk(rec_q[k + 1 + i] == sent[i], "R5 retimed data", rec_q[k + 1 + i], sent[i]);
        else
          chk(0, "R5 retimed data missing", i, 64);
      end

    // R4: no marks keep 12-cycle windows and hold lock
    clr_stats();
    repeat (40) send_bit(0, 0, 12, 0);
    chk(n11 == 0 && n13 == 0 && n12 >= 39, "R4 idle windows 12", n12, 40);
    chk(locked == 1, "R6 lock held over zeros", locked, 1);

    // R3: fast and slow sources tracked without slip
    clr_stats();
    base = win_cnt;
    repeat (200) send_bit(1, 0, 11, 0);
    chk(near(win_cnt - base, 200, 2), "R3 tracks 11-cycle source", win_cnt - base, 200);
    chk(n11 > 0, "R3 short windows used", n11, 1);
    clr_stats();
    base = win_cnt;
    repeat (200) send_bit(0, 1, 13, 0);
    chk(near(win_cnt - base, 200, 2), "R3 tracks 13-cycle source", win_cnt - base, 200);
    chk(n13 > 0, "R3 long windows used", n13, 1);

    // R7: carrier loss
    repeat (10) send_bit(1, 0, 12, 0);
    @(negedge clk) carrier_loss = 1;
    @(negedge clk);
    chk(locked == 0, "R7 loss drops lock", locked, 0);
    repeat (40) send_bit(1, 0, 12, 0);
    chk(locked == 0, "R7 low while loss held", locked, 0);
    carrier_loss = 0;
    expect_lock("R7 relock");

    // R6: periodic displaced edges block lock
    @(negedge clk) carrier_loss = 1;
    @(negedge clk) carrier_loss = 0;
    lock_seen = 0;
    for (int b = 0; b < 300; b++) send_bit(1, 0, 12, (b % 10 == 9) ? 4 : 0);
    chk(lock_seen == 0 && locked == 0, "R6 displaced edges restart run", locked, 0);
    expect_lock("R6 relock after clean run");

    // R8: rate change
    @(negedge clk) rate_e1 = 1;
    @(negedge clk);
    chk(locked == 0, "R8 rate change drops lock", locked, 0);
    expect_lock("R8 relock in E1 mode");
    clr_stats();
    repeat (20) send_bit(1, 0, 12, 0);
    chk(n11 == 0 && n13 == 0, "R8 E1 ratios same", n11 + n13, 0);

    // R1/R3: constrained random jitter
    base = win_cnt;
    k = 0;
    for (int b = 0; b < 400; b++) begin
      r = $urandom % 4;
      send_bit(r != 0, 0, 11 + ($urandom % 3), 0);
      k++;
    end
    chk(near(win_cnt - base, k, 4), "R3 random jitter no slip", win_cnt - base, k);

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    wait (cyc > 150000);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 150000);
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end
endmodule